// File: doc/BRIEF.md
# Transmit Serial Link Sequencer

This block controls when the transmit path sleeps and wakes, and it runs the serial data link from an external controller. The sleep request is sampled on the falling edge of the master clock. While the request is high, the block keeps a power-down enable asserted and holds its bit clock low. When the request is released, the block waits a fixed number of master cycles. It then pulses a reset to the downstream modulator, which returns the modulator to its idle all-ones state, and starts a divided bit clock.

The controller changes its serial data on the rising edge of the bit clock. The block captures that data on the falling edge and presents each captured bit with a one-cycle strobe in the master clock domain. The same divider also produces an oversampling tick for the modulator, and one tick lines up with every capture. If sleep is requested again, the bit clock, strobe and tick stop at the next master edge, even in the middle of a bit.

Top module: `txl_serial_link`

## Requirements
- R1: While reset is high, the outputs are held as follows: pwr_down is 1, and bit_clk, bit_strobe, bit_value, sample_tick and mod_reset are all 0.
- R2: sleep_req is sampled on the falling edge of clk. pwr_down follows that sample at the next rising edge of clk. If sleep_req is driven low just after a rising edge, pwr_down is still 1 at the following falling edge and is 0 one rising edge later.
- R3: bit_clk stays low during sleep and during the wake delay. It first goes high exactly WAKE_CYCLES (24) master cycles after the first rising edge of clk that sees the released sleep sample.
- R4: Once running, bit_clk has a period of DIV (48) master cycles. It begins high, stays high for DIV/2 cycles and low for DIV/2 cycles.
- R5: At each falling transition of bit_clk while awake, ser_din is captured. bit_strobe is high for exactly that one cycle, and bit_value carries the captured bit. bit_value does not change until the next strobe.
- R6: mod_reset is a single-cycle pulse in the cycle where bit_clk first goes high after wake-up, so it comes before the first strobe. An aborted wake delay produces no pulse.
- R7: When sleep is requested while running, bit_clk, bit_strobe and sample_tick go to 0 and pwr_down goes to 1, all at the rising edge after the falling-edge sample. The current bit is not completed.
- R8: If sleep_req rises again during the wake delay, the delay is abandoned. The next release waits the full WAKE_CYCLES again.
- R9: While running, sample_tick pulses OVS (16) times per bit clock period, once every DIV/OVS (3) master cycles. One of these pulses falls in the same cycle as each bit_strobe.
- R10: While asleep, ser_din is ignored: no strobe occurs and bit_value keeps its last captured bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Sleep request, 1 = sleep |
| ser_din | input | 1 | Serial data from the controller |
| bit_clk | output | 1 | Outgoing bit clock |
| bit_strobe | output | 1 | One-cycle strobe per captured bit |
| bit_value | output | 1 | Last captured bit |
| sample_tick | output | 1 | Oversampling tick for the modulator |
| mod_reset | output | 1 | Modulator reset-to-idle pulse |
| pwr_down | output | 1 | Power-down enable for the transmit path |

## Verification
The bench builds the block with its default parameters: WAKE_CYCLES of 24, DIV of 48 and OVS of 16. With these values the tick spacing is three cycles, which is not a power of two. The capture edge at phase 24 therefore has to land exactly on a tick, and any off-by-one in the tick counter phase shows up. A 24-cycle delay is short enough that the bench can cover many things in one run: a full wake delay, an aborted wake delay, eight-bit patterns, sleep in the middle of a bit and a reset while running.

// File: rtl/txl_pkg.sv
package txl_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_WAKE  = 2'd1,
    ST_RUN   = 2'd2
  } link_state_t;
endpackage

// File: rtl/txl_wake_ctrl.sv
// Sleep sampling, wake delay counter, power-down and modulator reset.
module txl_wake_ctrl
  import txl_pkg::*;
#(
  parameter int WAKE_CYCLES = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  output logic run_enter,
  output logic run_keep,
  output logic pwr_down,
  output logic mod_reset
);
  localparam int CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

  logic          sleep_s;
  link_state_t   st_q;
  logic [CW-1:0] cnt_q;

  // sleep request is taken on the falling master edge
  always_ff @(negedge clk) begin
    if (rst) sleep_s <= 1'b1;
    else     sleep_s <= sleep_req;
  end

  assign run_enter = (st_q == ST_WAKE) && !sleep_s && (cnt_q == LAST);
  assign run_keep  = (st_q == ST_RUN) && !sleep_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_SLEEP;
      cnt_q     <= '0;
      pwr_down  <= 1'b1;
      mod_reset <= 1'b0;
    end else begin
      pwr_down  <= sleep_s;
      mod_reset <= run_enter;
      unique case (st_q)
        ST_SLEEP: begin
          if (!sleep_s) begin
            st_q  <= ST_WAKE;
            cnt_q <= '0;
          end
        end
        ST_WAKE: begin
          if (sleep_s) begin
            st_q  <= ST_SLEEP;       // abandoned delay restarts later
            cnt_q <= '0;
          end else if (run_enter) begin
            st_q  <= ST_RUN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (sleep_s) st_q <= ST_SLEEP;
        end
        default: st_q <= ST_SLEEP;
      endcase
    end
  end
endmodule

// File: rtl/txl_bitclk_gen.sv
// Bit clock divider and oversampling tick, both registered.
module txl_bitclk_gen #(
  parameter int DIV = 48,
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run_enter,
  input  logic run_keep,
  output logic bit_clk,
  output logic sample_tick,
  output logic fall_now
);
  localparam int HALF = DIV / 2;
  localparam int TDIV = DIV / OVS;
  localparam int TPH  = HALF % TDIV;
  localparam int DW   = $clog2(DIV);

  logic [DW-1:0] div_q, div_nxt;
  logic          tick_nxt;

  assign div_nxt  = (div_q == DW'(DIV - 1)) ? '0 : div_q + 1'b1;
  assign fall_now = run_keep && (div_nxt == DW'(HALF));

  always_ff @(posedge clk) begin
    if (rst || !(run_enter || run_keep)) begin
      div_q   <= '0;
      bit_clk <= 1'b0;
    end else if (run_enter) begin
      div_q   <= '0;
      bit_clk <= 1'b1;
    end else begin
      div_q   <= div_nxt;
      bit_clk <= (div_nxt < DW'(HALF));
    end
  end

  generate
    if (TDIV == 1) begin : g_tick_every
      assign tick_nxt = 1'b1;
    end else begin : g_tick_count
      localparam int TW = $clog2(TDIV);
      logic [TW-1:0] tph_q, tph_nxt;
      assign tph_nxt  = (tph_q == TW'(TDIV - 1)) ? '0 : tph_q + 1'b1;
      assign tick_nxt = (tph_nxt == TW'(TPH));
      always_ff @(posedge clk) begin
        if (rst || run_enter || !run_keep) tph_q <= '0;
        else                               tph_q <= tph_nxt;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !run_keep) sample_tick <= 1'b0;
    else                  sample_tick <= tick_nxt;
  end
endmodule

// File: rtl/txl_capture.sv
// Captures serial data at the falling bit clock transition.
module txl_capture (
  input  logic clk,
  input  logic rst,
  input  logic fall_now,
  input  logic ser_din,
  output logic bit_strobe,
  output logic bit_value
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_strobe <= 1'b0;
      bit_value  <= 1'b0;
    end else begin
      bit_strobe <= fall_now;
      if (fall_now) bit_value <= ser_din;
    end
  end
endmodule

// File: rtl/txl_serial_link.sv
module txl_serial_link #(
  parameter int WAKE_CYCLES = 24,
  parameter int DIV         = 48,
  parameter int OVS         = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_req,
  input  logic ser_din,
  output logic bit_clk,
  output logic bit_strobe,
  output logic bit_value,
  output logic sample_tick,
  output logic mod_reset,
  output logic pwr_down
);
  logic run_enter, run_keep, fall_now;

  txl_wake_ctrl #(.WAKE_CYCLES(WAKE_CYCLES)) i_wake (
    .clk(clk), .rst(rst), .sleep_req(sleep_req),
    .run_enter(run_enter), .run_keep(run_keep),
    .pwr_down(pwr_down), .mod_reset(mod_reset)
  );

  txl_bitclk_gen #(.DIV(DIV), .OVS(OVS)) i_bclk (
    .clk(clk), .rst(rst), .run_enter(run_enter), .run_keep(run_keep),
    .bit_clk(bit_clk), .sample_tick(sample_tick), .fall_now(fall_now)
  );

  txl_capture i_cap (
    .clk(clk), .rst(rst), .fall_now(fall_now), .ser_din(ser_din),
    .bit_strobe(bit_strobe), .bit_value(bit_value)
  );
endmodule

// File: rtl/txl_serial_link_chk.sv
module txl_serial_link_chk (
  input logic clk,
  input logic rst,
  input logic bit_clk,
  input logic bit_strobe,
  input logic bit_value,
  input logic sample_tick,
  input logic mod_reset,
  input logic pwr_down
);
  p_quiet_in_sleep_r7: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> (!bit_clk && !bit_strobe && !sample_tick && !mod_reset));

  p_strobe_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |-> $fell(bit_clk));

  p_fall_gives_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(bit_clk) && !pwr_down) |-> bit_strobe);

  p_value_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !bit_strobe |-> $stable(bit_value));

  p_modrst_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    mod_reset |-> $rose(bit_clk));

  p_modrst_single_r6: assert property (@(posedge clk) disable iff (rst)
    mod_reset |=> !mod_reset);

  p_tick_at_capture_r9: assert property (@(posedge clk) disable iff (rst)
    bit_strobe |-> sample_tick);
endmodule

bind txl_serial_link txl_serial_link_chk i_chk (
  .clk(clk), .rst(rst), .bit_clk(bit_clk), .bit_strobe(bit_strobe),
  .bit_value(bit_value), .sample_tick(sample_tick),
  .mod_reset(mod_reset), .pwr_down(pwr_down)
);

// File: tb/test_txl_serial_link.sv
`timescale 1ns/1ps
module test_txl_serial_link;
  localparam int WAKE = 24;
  localparam int DIV  = 48;
  localparam int HALF = DIV / 2;
  localparam int NVEC = 4;
  localparam logic [7:0] PATS [NVEC] = '{8'hA5, 8'h3C, 8'hFF, 8'h00};

  logic clk = 1'b0, rst = 1'b1, sleep_req = 1'b1, ser_din = 1'b0;
  logic bit_clk, bit_strobe, bit_value, sample_tick, mod_reset, pwr_down;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  txl_serial_link #(.WAKE_CYCLES(WAKE), .DIV(DIV), .OVS(16)) i_txl_serial_link (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .ser_din(ser_din),
    .bit_clk(bit_clk), .bit_strobe(bit_strobe), .bit_value(bit_value),
    .sample_tick(sample_tick), .mod_reset(mod_reset), .pwr_down(pwr_down)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // release sleep just after a rising edge and check the wake timing
  task automatic do_wake(input string tag);
    int early = 0;
    @(posedge clk); #1 sleep_req = 1'b0;
    @(negedge clk);
    chk(pwr_down == 1'b1, "R2 before sample", pwr_down, 1);
    for (int k = 1; k <= WAKE + 1; k++) begin
      @(negedge clk);
      if (k == 1) chk(pwr_down == 1'b0, "R2 after sample", pwr_down, 0);
      if (k <= WAKE && (bit_clk || mod_reset || bit_strobe)) early++;
    end
    chk(early == 0, {tag, " clock held in delay"}, early, 0);
    chk(bit_clk == 1'b1, {tag, " first rise"}, bit_clk, 1);
    chk(mod_reset == 1'b1, "R6 reset pulse at first rise", mod_reset, 1);
  endtask

  // one bit period after a rising edge of bit_clk
  task automatic send_bit(input logic b);
    int shape = 0, strobes = 0, ticks = 0, badtick = 0;
    logic got = 1'b0;
    ser_din = b;
    for (int j = 1; j <= DIV; j++) begin
      @(negedge clk);
      if (bit_clk != ((j % DIV) < HALF)) shape++;
      if (mod_reset) shape++;
      if (bit_strobe) begin
        strobes++;
        got = bit_value;
        if (j != HALF) strobes += 10;
        if (!sample_tick) badtick++;
      end
      if (sample_tick) begin
        ticks++;
        if (j % 3 != 0) badtick++;
      end
    end
    chk(shape == 0, "R4 bit clock shape", shape, 0);
    chk(strobes == 1 && got == b, "R5 capture", int'(got), int'(b));
    chk(ticks == 16 && badtick == 0, "R9 ticks per bit", ticks, 16);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int bad;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pwr_down && !bit_clk && !bit_strobe && !bit_value && !sample_tick && !mod_reset,
        "R1 reset state", int'({pwr_down, bit_clk, bit_strobe, bit_value, sample_tick, mod_reset}), 32);
    @(posedge clk); #1 rst = 1'b0;
    repeat (4) @(posedge clk);

    for (int v = 0; v < NVEC; v++) begin
      do_wake("R3");
      for (int b = 7; b >= 0; b--) send_bit(PATS[v][b]);
      // sleep while bit_clk is high
      @(posedge clk); #1 sleep_req = 1'b1;
      @(negedge clk);
      chk(bit_clk == 1'b1, "R7 still high before sample", bit_clk, 1);
      @(negedge clk);
      chk(!bit_clk && pwr_down && !sample_tick, "R7 immediate stop",
          int'({bit_clk, pwr_down, sample_tick}), 2);
      bad = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        ser_din = ~ser_din;
        if (bit_strobe || bit_clk || sample_tick || bit_value != PATS[v][0]) bad++;
      end
      chk(bad == 0, "R10 data ignored in sleep", bad, 0);
    end

    // aborted wake delay, then a full restart
    @(posedge clk); #1 sleep_req = 1'b0;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (bit_clk || mod_reset) bad++;
    end
    @(posedge clk); #1 sleep_req = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (bit_clk || mod_reset) bad++;
    end
    chk(bad == 0, "R6 no pulse from aborted delay", bad, 0);
    do_wake("R8");
    send_bit(1'b1);

    // reset while running
    @(posedge clk); #1 rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(pwr_down && !bit_clk && !bit_strobe && !bit_value && !sample_tick && !mod_reset,
        "R1 reset while running", int'({pwr_down, bit_clk, bit_strobe, bit_value, sample_tick, mod_reset}), 32);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule